// File: doc/BRIEF.md
# Timer Count Latch and Status Readback

This block sits between one channel of a 16-bit down-counting timer and an 8-bit processor read port. The counting engine is outside it. The engine supplies the live count, the level of its output pin, and a pulse when a newly written count has been moved into the counting element. The block receives every write to the timer's shared control register. It decodes three kinds of word from those writes: a per-channel counter-latch command, a multi-channel read-back command, and a mode-programming word. From these it decides which byte each processor read returns.

A latch command freezes the live count in a holding register. Both halves of a two-byte read then come from the same instant, and the snapshot is held until it has been read completely. A read-back command can also freeze a status byte. The status byte carries the output pin level, a null-count flag and the six programmed control bits. When both a status byte and a count are frozen, the status byte is returned first. When nothing is frozen, reads follow the live count.

Control word layout:
- Bits [7:6] name the target channel (0 to 2). The value 3 marks a read-back command.
- For a channel word, bits [5:4] select the access: 00 latch command, 01 low byte only, 10 high byte only, 11 low byte then high byte.
- For a channel word, bits [3:0] are stored but not interpreted.

Top module: `cnt_readback`

## Requirements
- R1: After reset, the access field reads as 11 (low then high), the stored control bits are 6'b110000, nothing is frozen, the byte pointer is at the low byte and the null-count flag is 0. The first read therefore returns the live count's low byte.
- R2: When no count is frozen, every read returns a byte of the live count input as it stands in that cycle.
- R3: A latch command freezes the live count at the write, and the following reads return bytes of that frozen value even if the live count changes. The latch command is a write with bits [7:6] equal to CHAN_ID and bits [5:4] equal to 00, or a read-back word with bit 5 equal to 0 and bit (1+CHAN_ID) equal to 1.
- R4: A latch command that arrives while a frozen count is still unread leaves the frozen value unchanged.
- R5: The frozen count is released once its final byte has been read. With access 11 that is the second count read; with access 01 or 10 it is the first. Later reads return the live count.
- R6: With access 11, count reads alternate low byte then high byte. A byte pointer toggles on each count read. Every control-register write, whatever its target, returns the pointer to the low byte.
- R7: With access 01, every count read returns bits [7:0]. With access 10, every count read returns bits [15:8].
- R8: A read-back word with bit 4 equal to 0 and bit (1+CHAN_ID) equal to 1 freezes the status byte {out level, null flag, control bits [5:0]} at the write. Later status commands and input changes do not alter it until it has been read once.
- R9: When a status byte and a count are both frozen, the first read returns the status byte without moving the byte pointer. The reads after it return the count bytes.
- R10: The null-count flag is set by a count write and cleared by the load pulse from the engine. When both arrive in the same cycle, the flag is set.
- R11: A mode word (target CHAN_ID, access not 00) stores bits [5:0] as the control bits and discards any frozen count or status byte.
- R12: Words whose target is another channel, and read-back words whose bit (1+CHAN_ID) is 0, change no state of this channel other than resetting the byte pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_wr | input | 1 | Strobe for a control-register write |
| cw_data | input | 8 | Control word being written |
| cnt_wr | input | 1 | Strobe for a count write to this channel (sets null flag) |
| cnt_loaded | input | 1 | Pulse from the engine: count moved into the counting element |
| live_count | input | 16 | Running count from the engine |
| out_level | input | 1 | Current level of the channel's output pin |
| rd_stb | input | 1 | Processor read strobe; the state advances at the clock edge |
| rd_data | output | 8 | Byte returned for the read in this cycle |

## Verification
The hardest case to reach is a status byte and a count frozen together while the null flag and the output level keep moving underneath them. If the design mishandles this, it shows up only in the order of the bytes and in stale bits. The stimulus reaches it by setting the flag with a count write and changing the output level. It then issues a combined read-back word, changes the live count, the level and the flag again, and reads out the status byte, both count halves and one live byte. Ignored commands (a second latch, a second status command, another channel's words) are each followed by reads that show the frozen or stored state untouched.

// File: rtl/cnt_readback_pkg.sv
// Shared widths and control-word codes for the count readback unit.
// Assumes an 8-bit read port and a 16-bit count.
package cnt_readback_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;
    localparam int CTRL_W = 6;

    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_LOHI  = 2'b11
    } acc_e;

    localparam logic [1:0]        SEL_READBACK = 2'b11;
    localparam logic [CTRL_W-1:0] CTRL_RESET   = 6'b110000;
endpackage

// File: rtl/cnt_cw_decode.sv
// Decodes one control-register write into the actions for this channel.
// Purely combinational. Assumes CHAN_ID is 0, 1 or 2.
module cnt_cw_decode
    import cnt_readback_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic              cw_wr,
    input  logic [7:0]        cw_data,
    output logic              mode_wr,
    output logic              cnt_latch_req,
    output logic              sts_latch_req,
    output logic [CTRL_W-1:0] ctrl_bits
);
    localparam logic [1:0] MY_SEL = 2'(CHAN_ID);

    logic to_me;
    logic is_rb;
    logic rb_hit;

    // Classify the word: aimed at this channel, or a read-back selecting it
    always_comb begin
        to_me         = (cw_data[7:6] == MY_SEL);
        is_rb         = (cw_data[7:6] == SEL_READBACK);
        rb_hit        = is_rb && cw_data[1 + CHAN_ID];
        mode_wr       = cw_wr && to_me && (cw_data[5:4] != ACC_LATCH);
        cnt_latch_req = cw_wr && ((to_me && (cw_data[5:4] == ACC_LATCH))
                                  || (rb_hit && !cw_data[5]));
        sts_latch_req = cw_wr && rb_hit && !cw_data[4];
        ctrl_bits     = cw_data[CTRL_W-1:0];
    end
endmodule

// File: rtl/cnt_snap_hold.sv
// Holds a frozen copy of the live count from a latch command until the
// final byte is read or a mode word discards it. Extra commands while
// holding are ignored.
module cnt_snap_hold
    import cnt_readback_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             capture,
    input  logic             discard,
    input  logic             drained,
    input  logic [CNT_W-1:0] live_count,
    output logic             held_vld,
    output logic [CNT_W-1:0] held_count
);
    // Snapshot register with discard > drain > capture priority
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_vld   <= 1'b0;
            held_count <= '0;
        end else if (discard || (held_vld && drained)) begin
            held_vld   <= 1'b0;
        end else if (capture && !held_vld) begin
            held_vld   <= 1'b1;
            held_count <= live_count;
        end
    end

    // R3
    snap_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!held_vld && capture && !discard) |=> (held_vld && held_count == $past(live_count)));
    // R3
    snap_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_vld && !discard && !drained) |=> (held_vld && $stable(held_count)));
    // R4
    snap_relatch_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (held_vld && capture && !discard) |=> $stable(held_count));
endmodule

// File: rtl/cnt_status_unit.sv
// Keeps the programmed control bits and the null-count flag, and freezes
// the composite status byte on request until it has been read once.
module cnt_status_unit
    import cnt_readback_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [CTRL_W-1:0] ctrl_bits,
    input  logic              cnt_wr,
    input  logic              cnt_loaded,
    input  logic              out_level,
    input  logic              sts_req,
    input  logic              sts_taken,
    output logic [1:0]        access,
    output logic              sts_vld,
    output logic [BYTE_W-1:0] sts_byte
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              null_q;

    // Control bits follow each mode word for this channel
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= CTRL_RESET;
        else if (mode_wr) ctrl_q <= ctrl_bits;
    end

    // Null flag: a count write sets it and wins over the load pulse
    always_ff @(posedge clk) begin
        if (!rst_n)          null_q <= 1'b0;
        else if (cnt_wr)     null_q <= 1'b1;
        else if (cnt_loaded) null_q <= 1'b0;
    end

    // Status snapshot: cleared by a mode word or one read, else captured once
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sts_vld  <= 1'b0;
            sts_byte <= '0;
        end else if (mode_wr || (sts_vld && sts_taken)) begin
            sts_vld  <= 1'b0;
        end else if (sts_req && !sts_vld) begin
            sts_vld  <= 1'b1;
            sts_byte <= {out_level, null_q, ctrl_q};
        end
    end

    assign access = ctrl_q[5:4];

    // R10
    null_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> null_q);
    // R10
    null_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_loaded && !cnt_wr) |=> !null_q);
    // R8
    sts_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vld && !sts_taken && !mode_wr) |=> (sts_vld && $stable(sts_byte)));
    // R11
    mode_discards_sts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !sts_vld);
endmodule

// File: rtl/cnt_byte_sel.sv
// Byte pointer and read-data selection. A frozen status byte goes out
// first; count bytes follow the access field and the pointer.
module cnt_byte_sel
    import cnt_readback_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  logic              rd_eff,
    input  logic [1:0]        access,
    input  logic              sts_vld,
    input  logic [BYTE_W-1:0] sts_byte,
    input  logic [CNT_W-1:0]  count_src,
    output logic [BYTE_W-1:0] rd_data,
    output logic              sts_taken,
    output logic              cnt_drained
);
    logic ptr_hi;
    logic pick_hi;
    logic cnt_rd;

    // Pointer: reset on any control write, toggles on low/high count reads
    always_ff @(posedge clk) begin
        if (!rst_n)                              ptr_hi <= 1'b0;
        else if (cw_wr)                          ptr_hi <= 1'b0;
        else if (cnt_rd && access == ACC_LOHI)   ptr_hi <= ~ptr_hi;
    end

    // Output mux and read-completion strobes
    always_comb begin
        cnt_rd      = rd_eff && !sts_vld;
        sts_taken   = rd_eff && sts_vld;
        pick_hi     = (access == ACC_HI) || (access == ACC_LOHI && ptr_hi);
        cnt_drained = cnt_rd && ((access != ACC_LOHI) || ptr_hi);
        if (sts_vld)      rd_data = sts_byte;
        else if (pick_hi) rd_data = count_src[CNT_W-1:BYTE_W];
        else              rd_data = count_src[BYTE_W-1:0];
    end

    // R6
    ptr_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |=> !ptr_hi);
    // R9
    sts_read_keeps_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_vld && rd_eff) |=> $stable(ptr_hi));
endmodule

// File: rtl/cnt_readback.sv
// Count latch and status readback for one timer channel. Decodes control
// writes, freezes count and status snapshots and sequences byte reads.
// Assumes a read in the same cycle as a control write is ignored.
module cnt_readback
    import cnt_readback_pkg::*;
#(
    parameter int CHAN_ID = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cw_wr,
    input  logic [7:0]  cw_data,
    input  logic        cnt_wr,
    input  logic        cnt_loaded,
    input  logic [15:0] live_count,
    input  logic        out_level,
    input  logic        rd_stb,
    output logic [7:0]  rd_data
);
    logic              mode_wr;
    logic              cnt_latch_req;
    logic              sts_latch_req;
    logic [CTRL_W-1:0] ctrl_bits;
    logic              held_vld;
    logic [CNT_W-1:0]  held_count;
    logic [1:0]        access;
    logic              sts_vld;
    logic [BYTE_W-1:0] sts_byte;
    logic              sts_taken;
    logic              cnt_drained;
    logic              rd_eff;
    logic [CNT_W-1:0]  count_src;

    // Control writes take precedence over a read in the same cycle
    always_comb begin
        rd_eff    = rd_stb && !cw_wr;
        count_src = held_vld ? held_count : live_count;
    end

    cnt_cw_decode #(.CHAN_ID(CHAN_ID)) u_dec (
        .cw_wr         (cw_wr),
        .cw_data       (cw_data),
        .mode_wr       (mode_wr),
        .cnt_latch_req (cnt_latch_req),
        .sts_latch_req (sts_latch_req),
        .ctrl_bits     (ctrl_bits)
    );

    cnt_snap_hold u_snap (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (cnt_latch_req),
        .discard    (mode_wr),
        .drained    (cnt_drained),
        .live_count (live_count),
        .held_vld   (held_vld),
        .held_count (held_count)
    );

    cnt_status_unit u_sts (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_wr    (mode_wr),
        .ctrl_bits  (ctrl_bits),
        .cnt_wr     (cnt_wr),
        .cnt_loaded (cnt_loaded),
        .out_level  (out_level),
        .sts_req    (sts_latch_req),
        .sts_taken  (sts_taken),
        .access     (access),
        .sts_vld    (sts_vld),
        .sts_byte   (sts_byte)
    );

    cnt_byte_sel u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .cw_wr       (cw_wr),
        .rd_eff      (rd_eff),
        .access      (access),
        .sts_vld     (sts_vld),
        .sts_byte    (sts_byte),
        .count_src   (count_src),
        .rd_data     (rd_data),
        .sts_taken   (sts_taken),
        .cnt_drained (cnt_drained)
    );

    // R5
    release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_drained |=> !held_vld);
    // R11
    mode_discards_snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr |=> !held_vld);
endmodule

// File: tb/cnt_readback_tb.sv
`timescale 1ns/1ps
module cnt_readback_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_wr = 1'b0;
    logic [7:0]  cw_data = '0;
    logic        cnt_wr = 1'b0;
    logic        cnt_loaded = 1'b0;
    logic [15:0] live_count = 16'h1234;
    logic        out_level = 1'b0;
    logic        rd_stb = 1'b0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2.5 clk = ~clk;

    cnt_readback #(.CHAN_ID(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .cw_wr(cw_wr), .cw_data(cw_data),
        .cnt_wr(cnt_wr), .cnt_loaded(cnt_loaded), .live_count(live_count),
        .out_level(out_level), .rd_stb(rd_stb), .rd_data(rd_data)
    );

    // Driver: one read strobe with its expected byte queued
    task automatic rd_exp(input logic [7:0] e, input string tag);
        @(negedge clk);
        rd_stb = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic cw(input logic [7:0] b);
        @(negedge clk);
        cw_wr = 1'b1;
        cw_data = b;
        @(negedge clk);
        cw_wr = 1'b0;
    endtask

    task automatic set_live(input logic [15:0] v);
        @(negedge clk);
        live_count = v;
    endtask

    task automatic pulse(input logic do_wr, input logic do_ld);
        @(negedge clk);
        cnt_wr = do_wr;
        cnt_loaded = do_ld;
        @(negedge clk);
        cnt_wr = 1'b0;
        cnt_loaded = 1'b0;
    endtask

    // Monitor: samples mid-cycle while a read is presented
    always @(negedge clk) begin
        #2;
        if (rd_stb) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL unexpected read: got %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    fails++;
                    $display("FAIL %s: got %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        fails++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R6 ordering and wrap
        rd_exp(8'h34, "R1 first read low byte");
        rd_exp(8'h12, "R6 second read high byte");
        rd_exp(8'h34, "R6 pointer wraps to low");
        cw(8'h34);
        rd_exp(8'h34, "R6 control write resets pointer");
        // R2 live following
        set_live(16'hABCD);
        rd_exp(8'hAB, "R2 live high byte");
        set_live(16'h5566);
        rd_exp(8'h66, "R2 live low byte");
        // R3 frozen count, R5 release
        set_live(16'hBEEF);
        cw(8'h00);
        set_live(16'h0102);
        rd_exp(8'hEF, "R3 frozen low");
        set_live(16'h0304);
        rd_exp(8'hBE, "R3 frozen high");
        rd_exp(8'h04, "R5 released after two reads");
        cw(8'h34);
        // R4 second latch ignored
        set_live(16'h2A5B);
        cw(8'h00);
        set_live(16'h3C4D);
        cw(8'h00);
        set_live(16'h6E7F);
        rd_exp(8'h5B, "R4 relatch ignored low");
        rd_exp(8'h2A, "R4 relatch ignored high");
        rd_exp(8'h7F, "R5 live after release");
        // R7 single-byte access modes
        cw(8'h10);
        set_live(16'h9A8B);
        rd_exp(8'h8B, "R7 low only");
        rd_exp(8'h8B, "R7 low only repeat");
        cw(8'h00);
        set_live(16'h0000);
        rd_exp(8'h8B, "R5 low-only frozen");
        rd_exp(8'h00, "R5 low-only released after one read");
        cw(8'h20);
        set_live(16'h7766);
        rd_exp(8'h77, "R7 high only");
        rd_exp(8'h77, "R7 high only repeat");
        // R8 status freeze, R10 null flag
        cw(8'h3A);
        pulse(1'b1, 1'b0);
        @(negedge clk) out_level = 1'b1;
        cw(8'hE2);
        @(negedge clk) out_level = 1'b0;
        pulse(1'b0, 1'b1);
        cw(8'hE2);
        rd_exp(8'hFA, "R8 status frozen");
        set_live(16'h0F1E);
        rd_exp(8'h1E, "R8 status read once then live");
        cw(8'hE2);
        rd_exp(8'h3A, "R10 null cleared by load");
        pulse(1'b1, 1'b1);
        cw(8'hE2);
        rd_exp(8'h7A, "R10 set wins over load");
        // R9 status ahead of count
        set_live(16'h4321);
        @(negedge clk) out_level = 1'b1;
        cw(8'hC2);
        set_live(16'h0000);
        rd_exp(8'hFA, "R9 status first");
        rd_exp(8'h21, "R9 count low next");
        rd_exp(8'h43, "R9 count high next");
        rd_exp(8'h00, "R9 then live");
        // R12 other channels ignored
        set_live(16'h1357);
        cw(8'hC4);
        cw(8'h7F);
        cw(8'h40);
        set_live(16'h2468);
        rd_exp(8'h68, "R12 no latch from other channel");
        cw(8'hE2);
        rd_exp(8'hFA, "R12 control bits unchanged");
        // R11 mode word discards latches
        cw(8'h00);
        cw(8'h30);
        set_live(16'h1122);
        rd_exp(8'h22, "R11 count latch discarded");
        cw(8'hE2);
        rd_exp(8'hF0, "R11 new control bits in status");
        cw(8'hE2);
        cw(8'h30);
        rd_exp(8'h22, "R11 status latch discarded");
        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            checks++;
            fails++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule